// File: doc/BRIEF.md
# Associative Block Address Mapper

This block turns a 27-bit logical address from the processor bus into a physical RAM address for one memory board. The upper 15 bits of the logical address form a tag. The tag is compared in the same cycle against 32 loadable mapper entries, and each entry stands for one 4K-word block of RAM. The lower 12 bits pass through unchanged: 8 of them become the row (X) address and 4 of them become the low part of the column (Y) address.

When an enabled entry holds the presented tag, the index of that entry produces the rest of the physical address. Index bits [4:3] pick one of four RAM rows through a one-hot chip-select bus. Index bits [2:0] become the three block-select bits at the top of the Y address. Each entry has a mask bit. While the mask bit is set, the entry cannot match. The board therefore answers only for the logical blocks that software has mapped onto it. With a 64K-word board, only entries whose index bit 2 is clear are in use.

Software loads an entry by giving its index and a 16-bit data word, in which bits [15:1] are the tag and bit 0 is the mask. The lookup path has no registers, so the translated outputs follow the logical address in the same cycle.

Top module: `blkmap_cam`

## Requirements
- R1: After reset, every entry has its mask bit set, so any logical address gives hit=0 and miss=1 until an entry has been written.
- R2: When wr_en is high at a rising clock edge, the entry selected by wr_idx takes its tag from wr_data[15:1] and its mask from wr_data[0]. The new contents affect the lookup outputs only after that edge, not before it.
- R3: An entry whose mask is clear and whose tag equals lad[26:12] gives hit=1 and miss=0.
- R4: An entry whose mask is set never produces a hit, even when its tag equals lad[26:12].
- R5: On a hit, exactly one chip-select line is high: cs[k], where k is bits [4:3] of the index of the winning entry.
- R6: phys_x always equals lad[7:0], and phys_y[3:0] always equals lad[11:8]. On a hit, phys_y[6:4] equals bits [2:0] of the index of the winning entry.
- R7: On a miss (miss=1, hit=0), all of cs is 0, phys_y[6:4] is 0 and multi_hit is 0.
- R8: When two or more unmasked entries match, the entry with the lowest index wins and multi_hit=1. When exactly one entry matches, multi_hit=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sets every mask bit |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | 5 | Index of the entry to write |
| wr_data | input | 16 | Tag in [15:1], mask in [0] |
| lad | input | 27 | Logical address |
| hit | output | 1 | An unmasked entry matches |
| miss | output | 1 | No unmasked entry matches |
| multi_hit | output | 1 | More than one unmasked entry matches |
| cs | output | 4 | One-hot RAM row select |
| phys_x | output | 8 | Row (X) address |
| phys_y | output | 7 | Column (Y) address, block bits on top |

## Verification
The bench loads two unmasked entries with the same tag. A design with the priority reversed would select the higher index, so the wrong chip select and block bits would appear; a design without duplicate detection would leave multi_hit low. The bench also sets the mask on an entry whose tag matches. A design that ignores the mask would still report a hit. It also looks up an address in the cycle before a write lands, which exposes a lookup that bypasses the entry registers. The bench places entries in each of the four rows, so a wrong slice of the index for the chip select or the Y bits shows up as the wrong row or block.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;
   localparam int unsigned DEF_TAG_W   = 15;
   localparam int unsigned DEF_PASS_W  = 12;
   localparam int unsigned DEF_X_W     = 8;
   localparam int unsigned DEF_ENTRIES = 32;
   localparam int unsigned DEF_BLK_W   = 3;

   // lookup result carried between the priority stage and the decode stage
   typedef struct packed {
      logic any;
      logic multi;
   } match_flags_t;
endpackage

// File: rtl/blkmap_entry_bank.sv
module blkmap_entry_bank #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned TAG_W   = 15,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [TAG_W-1:0]              wr_tag,
   input  logic                          wr_mask,
   output logic [ENTRIES-1:0][TAG_W-1:0] tags,
   output logic [ENTRIES-1:0]            masks
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tags[e]  <= '0;
            masks[e] <= 1'b1;
         end else if (sel) begin
            tags[e]  <= wr_tag;
            masks[e] <= wr_mask;
         end
      end
   end
endmodule

// File: rtl/blkmap_match.sv
module blkmap_match #(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned TAG_W   = 15
) (
   input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
   input  logic [ENTRIES-1:0]            masks,
   input  logic [TAG_W-1:0]              key,
   output logic [ENTRIES-1:0]            match
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match[e] = !masks[e] && (tags[e] == key);
   end
endmodule

// File: rtl/blkmap_prio.sv
module blkmap_prio
   import blkmap_pkg::*;
#(
   parameter int unsigned ENTRIES = 32,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] match,
   output logic [IDX_W-1:0]   win_idx,
   output match_flags_t       flags
);
   logic [ENTRIES-1:0] rest;

   // lowest index wins: scan from the top so the last assignment is the lowest
   always_comb begin
      win_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) win_idx = IDX_W'(i);
      end
   end

   // clearing the lowest set bit leaves something only if two or more matched
   assign rest        = match & (match - ENTRIES'(1));
   assign flags.any   = |match;
   assign flags.multi = |rest;
endmodule

// File: rtl/blkmap_cam.sv
module blkmap_cam
   import blkmap_pkg::*;
#(
   parameter int unsigned TAG_W   = DEF_TAG_W,
   parameter int unsigned PASS_W  = DEF_PASS_W,
   parameter int unsigned X_W     = DEF_X_W,
   parameter int unsigned ENTRIES = DEF_ENTRIES,
   parameter int unsigned BLK_W   = DEF_BLK_W,
   localparam int unsigned ADDR_W = TAG_W + PASS_W,
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned ROW_W  = IDX_W - BLK_W,
   localparam int unsigned ROWS   = 1 << ROW_W,
   localparam int unsigned YLO_W  = PASS_W - X_W,
   localparam int unsigned Y_W    = YLO_W + BLK_W,
   localparam int unsigned WD_W   = TAG_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WD_W-1:0]   wr_data,
   input  logic [ADDR_W-1:0] lad,
   output logic              hit,
   output logic              miss,
   output logic              multi_hit,
   output logic [ROWS-1:0]   cs,
   output logic [X_W-1:0]    phys_x,
   output logic [Y_W-1:0]    phys_y
);
   if (ENTRIES != (1 << IDX_W)) begin : g_bad_entries
      $error("ENTRIES must be a power of two");
   end
   if (BLK_W >= IDX_W) begin : g_bad_blk
      $error("BLK_W must leave at least one row-select bit");
   end
   if (X_W >= PASS_W) begin : g_bad_x
      $error("X_W must leave pass-through bits for Y");
   end

   logic [ENTRIES-1:0][TAG_W-1:0] tags;
   logic [ENTRIES-1:0]            masks;
   logic [ENTRIES-1:0]            match;
   logic [IDX_W-1:0]              win_idx;
   match_flags_t                  flags;
   logic [TAG_W-1:0]              key;
   logic [BLK_W-1:0]              blk;
   logic [ROW_W-1:0]              row;

   assign key = lad[ADDR_W-1 -: TAG_W];

   blkmap_entry_bank #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_tag  (wr_data[WD_W-1:1]),
      .wr_mask (wr_data[0]),
      .tags    (tags),
      .masks   (masks)
   );

   blkmap_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
      .tags  (tags),
      .masks (masks),
      .key   (key),
      .match (match)
   );

   blkmap_prio #(.ENTRIES(ENTRIES)) u_prio (
      .match   (match),
      .win_idx (win_idx),
      .flags   (flags)
   );

   assign hit       = flags.any;
   assign miss      = !flags.any;
   assign multi_hit = flags.multi;
   assign row       = win_idx[IDX_W-1:BLK_W];
   assign blk       = flags.any ? win_idx[BLK_W-1:0] : '0;

   for (genvar r = 0; r < ROWS; r++) begin : g_cs
      assign cs[r] = flags.any && (row == ROW_W'(r));
   end

   assign phys_x = lad[X_W-1:0];
   assign phys_y = {blk, lad[PASS_W-1:X_W]};
endmodule

// File: rtl/blkmap_cam_chk.sv
module blkmap_cam_chk #(
   parameter int unsigned ADDR_W = 27,
   parameter int unsigned ROWS   = 4,
   parameter int unsigned X_W    = 8,
   parameter int unsigned Y_W    = 7,
   parameter int unsigned PASS_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] lad,
   input logic              hit,
   input logic              miss,
   input logic              multi_hit,
   input logic [ROWS-1:0]   cs,
   input logic [X_W-1:0]    phys_x,
   input logic [Y_W-1:0]    phys_y
);
   localparam int unsigned YLO_W = PASS_W - X_W;
   logic written;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) written <= 1'b0;
      else if (wr_en) written <= 1'b1;
   end

   // R1
   reset_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !written |-> (!hit && miss));
   // R5
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> ($countones(cs) == 1));
   // R6
   pass_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phys_x == lad[X_W-1:0]) && (phys_y[YLO_W-1:0] == lad[PASS_W-1:X_W]));
   // R7
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss |-> (!hit && cs == '0 && phys_y[Y_W-1:YLO_W] == '0 && !multi_hit));
   // R8
   multi_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      multi_hit |-> hit);
endmodule

bind blkmap_cam blkmap_cam_chk #(
   .ADDR_W(ADDR_W), .ROWS(ROWS), .X_W(X_W), .Y_W(Y_W), .PASS_W(PASS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lad(lad), .hit(hit),
   .miss(miss), .multi_hit(multi_hit), .cs(cs), .phys_x(phys_x), .phys_y(phys_y)
);

// File: tb/blkmap_cam_tb.sv
`timescale 1ns/1ps
module blkmap_cam_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_idx = '0;
   logic [15:0] wr_data = '0;
   logic [26:0] lad = '0;
   logic        hit, miss, multi_hit;
   logic [3:0]  cs;
   logic [7:0]  phys_x;
   logic [6:0]  phys_y;

   int checks = 0;
   int fails = 0;
   logic [14:0] m_tag [32];
   logic        m_mask [32];
   logic [14:0] pool [4];

   always #2 clk = ~clk;

   blkmap_cam u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .lad(lad), .hit(hit), .miss(miss), .multi_hit(multi_hit), .cs(cs),
      .phys_x(phys_x), .phys_y(phys_y)
   );

   // packed as {hit, miss, multi_hit, cs[3:0], phys_x[7:0], phys_y[6:0]}
   function automatic logic [21:0] expect_out(input logic [26:0] a);
      int win = -1;
      int cnt = 0;
      logic [3:0] c = '0;
      logic [2:0] b = '0;
      for (int i = 0; i < 32; i++) begin
         if (!m_mask[i] && m_tag[i] == a[26:12]) begin
            cnt++;
            if (win < 0) win = i;
         end
      end
      if (win >= 0) begin
         c = 4'b0001 << (win / 8);
         b = 3'(win % 8);
      end
      return {win >= 0, win < 0, cnt > 1, c, a[7:0], b, a[11:8]};
   endfunction

   task automatic check_lookup(input logic [26:0] a, input string req);
      logic [21:0] act, exp;
      lad = a;
      #1;
      act = {hit, miss, multi_hit, cs, phys_x, phys_y};
      exp = expect_out(a);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s lad=%h actual=%h expected=%h", req, a, act, exp);
      end
   endtask

   task automatic write_entry(input int idx, input logic [14:0] tag, input logic mask);
      @(negedge clk);
      wr_en = 1'b1;
      wr_idx = 5'(idx);
      wr_data = {tag, mask};
      @(posedge clk);
      m_tag[idx] = tag;
      m_mask[idx] = mask;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #400000;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      for (int i = 0; i < 32; i++) begin
         m_tag[i] = '0;
         m_mask[i] = 1'b1;
      end
      pool[0] = 15'h1234; pool[1] = 15'h0000; pool[2] = 15'h7fff; pool[3] = 15'h2a5a;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state, even tag zero must miss
      check_lookup(27'h0000abc, "R1");
      check_lookup({15'h1234, 12'hfed}, "R1");

      // R2: write not visible before the edge, visible after
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 5'd5; wr_data = {15'h1234, 1'b0};
      check_lookup({15'h1234, 12'h3c7}, "R2");
      @(posedge clk);
      m_tag[5] = 15'h1234; m_mask[5] = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
      // R3 R5 R6: entry 5 gives cs[0], block 5
      check_lookup({15'h1234, 12'h3c7}, "R3");
      check_lookup({15'h1235, 12'h3c7}, "R7");

      // R4: mask set on a matching tag
      write_entry(5, 15'h1234, 1'b1);
      check_lookup({15'h1234, 12'h3c7}, "R4");

      // R5: one entry per row
      write_entry(9,  15'h0101, 1'b0);
      write_entry(18, 15'h0202, 1'b0);
      write_entry(27, 15'h0303, 1'b0);
      check_lookup({15'h0101, 12'h9a5}, "R5");
      check_lookup({15'h0202, 12'h011}, "R5");
      check_lookup({15'h0303, 12'hfff}, "R6");

      // R8: duplicate tag, lowest index wins
      write_entry(20, 15'h4444, 1'b0);
      check_lookup({15'h4444, 12'h123}, "R8");
      write_entry(10, 15'h4444, 1'b0);
      check_lookup({15'h4444, 12'h123}, "R8");
      write_entry(10, 15'h4444, 1'b1);
      check_lookup({15'h4444, 12'h456}, "R8");

      // random mix of writes and lookups over a small tag pool
      for (int n = 0; n < 400; n++) begin
         if ($urandom_range(0, 2) == 0)
            write_entry($urandom_range(0, 31), pool[$urandom_range(0, 3)], 1'($urandom_range(0, 1)));
         check_lookup({pool[$urandom_range(0, 3)], 12'($urandom)}, "R3");
         @(negedge clk);
      end

      // R1: reset again clears every mapping
      rst_n = 1'b0;
      for (int i = 0; i < 32; i++) m_mask[i] = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      check_lookup({15'h0303, 12'h555}, "R1");
      report();
   end
endmodule